// File: doc/BRIEF.md
# Machine Check Error Bank Recorder

This block holds the error-logging state for a processor's machine-check machinery. It has a set of banks. Each bank has four 64-bit registers: control, status, address and misc. There are also three global registers: a read-only capability word, a global control word and a global status word. Hardware error sources offer one error per cycle on an injection port. Each error carries a target bank, a status word, a new global status value, an address and a misc value. The recorder decides what to do with it. It may drop the error, record it, set overflow on the existing entry, or raise a reset request when an uncorrected error cannot be delivered as an exception.

An accepted uncorrected error produces a one-cycle exception request. A reset request stays high until the surrounding logic acknowledges it. Software sees every register through a simple address/data port. Reads are combinational and writes take effect at the clock edge.

The set of enabled features is fixed while reset is asserted. The recorder is live only for a capable CPU: a family code of 6 or more and both feature flags present. Otherwise it reports zero banks and ignores all errors.

Top module: `mcb_recorder`

## Requirements
- R1: While `rst_n` is low the block samples `cfg_family`, `cfg_feat_chk` and `cfg_feat_arch`. It is enabled only if the family is at least 6 and both flags are 1. When enabled, the capability register (address 0x00) reads bank count CAP_BANKS in bits 7:0 with bit 8 set, and the global control and every bank control register read all ones. When disabled, all of these read zero and every injection is ignored.
- R2: An injection is ignored, with no state change and no request, when either of these holds: the bank index is not below the count in capability bits 7:0, or the status valid bit (bit 63) is clear.
- R3: An uncorrected error (status bit 61 set) is dropped when capability bit 8 is set and global control is not all ones.
- R4: An uncorrected error is dropped when the target bank's control register is not all ones.
- R5: An uncorrected error that passes R3 and R4 does the following when global status bit 2 (in-progress) is set or `cr_mc_enable` is low. It records nothing and raises `rst_req` one cycle later. `rst_req` stays high until `rst_ack` is sampled high.
- R6: An accepted uncorrected error writes the bank address, misc and status and the global status. Status bit 62 (overflow) is set in the new status if the bank already held a valid entry. `mce_req` is high for exactly the cycle after the accepting edge.
- R7: A valid corrected error (bit 61 clear) is fully recorded when the bank holds no valid entry or a valid corrected entry. Overflow bit 62 is set in the new status in the latter case. No request is raised.
- R8: A corrected error aimed at a bank holding a valid uncorrected entry only sets bit 62 of the existing status. The other bank registers are left unchanged.
- R9: The register map is as follows:
  - 0x01 is global control and 0x02 is global status.
  - 0x40 + 4*bank + field is a bank register, with fields 0 control, 1 status, 2 address, 3 misc.
  - The capability register is read-only.
  - Bank registers at or beyond the configured count read zero and ignore writes.
  - Other addresses read zero.
- R10: `inj_ready` is low in any cycle where `reg_wr_en` is high. An injection offered in such a cycle is not taken, and the register write applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_family | input | 4 | CPU family code, sampled during reset |
| cfg_feat_chk | input | 1 | Machine-check exception feature flag, sampled during reset |
| cfg_feat_arch | input | 1 | Machine-check architecture feature flag, sampled during reset |
| cr_mc_enable | input | 1 | CPU control bit allowing machine-check exceptions |
| inj_valid | input | 1 | Error injection offered |
| inj_ready | output | 1 | Injection accepted this cycle when high |
| inj_bank | input | 8 | Target bank index |
| inj_status | input | 64 | Bank status word of the error |
| inj_gstatus | input | 64 | Global status value for an uncorrected error |
| inj_addr | input | 64 | Error address |
| inj_misc | input | 64 | Error misc value |
| reg_addr | input | 8 | Register address for read and write |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational |
| mce_req | output | 1 | One-cycle machine-check exception request |
| rst_req | output | 1 | Reset request, held until acknowledged |
| rst_ack | input | 1 | Clears the reset request |

## Verification
Two kinds of cycle overlap are exercised: a software register write colliding with an error injection, and a reset acknowledge with the request it clears. For the first, the bench offers a corrected error to a bank in the same cycle it writes that bank's address register. A reference model decides the outcome, and the bench then reads back: the write must land, the status must stay empty, and `inj_ready` must be low in that cycle. The reference model also tracks exception and reset requests every cycle. It compares them against the ports, so any extra, missing or stretched pulse is caught.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
    localparam int DATA_W   = 64;
    localparam int VAL_BIT  = 63;
    localparam int OVER_BIT = 62;
    localparam int UC_BIT   = 61;
    localparam int MCIP_BIT = 2;
    localparam int CTLP_BIT = 8;

    localparam int F_CTL  = 0;
    localparam int F_STAT = 1;
    localparam int F_ADDR = 2;
    localparam int F_MISC = 3;

    localparam logic [7:0] A_CAP  = 8'h00;
    localparam logic [7:0] A_GCTL = 8'h01;
    localparam logic [7:0] A_GST  = 8'h02;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_RESET,
        ACT_UC_REC,
        ACT_CE_REC,
        ACT_OVER_ONLY
    } act_e;
endpackage

// File: rtl/mcb_decide.sv
module mcb_decide
    import mcb_pkg::*;
(
    input  logic              in_range,
    input  logic [DATA_W-1:0] new_st,
    input  logic [DATA_W-1:0] old_st,
    input  logic              ctl_present,
    input  logic              gctl_ones,
    input  logic              bctl_ones,
    input  logic              in_progress,
    input  logic              cr_en,
    output act_e              act,
    output logic [DATA_W-1:0] st_out
);
    always_comb begin
        act    = ACT_NONE;
        st_out = new_st;
        if (in_range && new_st[VAL_BIT]) begin
            if (new_st[UC_BIT]) begin
                if (ctl_present && !gctl_ones) begin
                    act = ACT_NONE;
                end else if (!bctl_ones) begin
                    act = ACT_NONE;
                end else if (in_progress || !cr_en) begin
                    act = ACT_RESET;
                end else begin
                    act = ACT_UC_REC;
                    if (old_st[VAL_BIT]) st_out[OVER_BIT] = 1'b1;
                end
            end else if (!old_st[VAL_BIT] || !old_st[UC_BIT]) begin
                act = ACT_CE_REC;
                if (old_st[VAL_BIT]) st_out[OVER_BIT] = 1'b1;
            end else begin
                act    = ACT_OVER_ONLY;
                st_out = old_st;
                st_out[OVER_BIT] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mcb_regmap.sv
module mcb_regmap
    import mcb_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic [7:0]                            addr,
    input  logic [7:0]                            cnt,
    input  logic [DATA_W-1:0]                     cap,
    input  logic [DATA_W-1:0]                     gctl,
    input  logic [DATA_W-1:0]                     gst,
    input  logic [NUM_BANKS-1:0][3:0][DATA_W-1:0] bank,
    output logic [DATA_W-1:0]                     rdata,
    output logic                                  sel_gctl,
    output logic                                  sel_gst,
    output logic                                  sel_bank,
    output logic [BANK_W-1:0]                     bidx,
    output logic [1:0]                            fld
);
    localparam logic [7:0] NB8 = 8'(NUM_BANKS);

    logic [7:0] bnum;

    always_comb begin
        bnum     = {4'b0, addr[5:2]};
        bidx     = addr[2 +: BANK_W];
        fld      = addr[1:0];
        sel_gctl = (addr == A_GCTL);
        sel_gst  = (addr == A_GST);
        sel_bank = (addr[7:6] == 2'b01) && (bnum < cnt) && (bnum < NB8);
        rdata    = '0;
        if (addr == A_CAP)  rdata = cap;
        else if (sel_gctl)  rdata = gctl;
        else if (sel_gst)   rdata = gst;
        else if (sel_bank)  rdata = bank[bidx][fld];
    end
endmodule

// File: rtl/mcb_recorder.sv
module mcb_recorder
    import mcb_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CAP_BANKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cfg_family,
    input  logic              cfg_feat_chk,
    input  logic              cfg_feat_arch,
    input  logic              cr_mc_enable,
    input  logic              inj_valid,
    output logic              inj_ready,
    input  logic [7:0]        inj_bank,
    input  logic [DATA_W-1:0] inj_status,
    input  logic [DATA_W-1:0] inj_gstatus,
    input  logic [DATA_W-1:0] inj_addr,
    input  logic [DATA_W-1:0] inj_misc,
    input  logic [7:0]        reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mce_req,
    output logic              rst_req,
    input  logic              rst_ack
);
    localparam int         BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam logic [7:0] NB8    = 8'(NUM_BANKS);
    localparam logic [7:0] CB8    = 8'(CAP_BANKS);

    typedef struct packed {
        logic [NUM_BANKS-1:0][3:0][DATA_W-1:0] bank;
        logic [DATA_W-1:0]                     cap;
        logic [DATA_W-1:0]                     gctl;
        logic [DATA_W-1:0]                     gst;
        logic                                  mce;
        logic                                  rst;
    } state_t;

    state_t q, d, rv;

    logic [7:0]        cnt;
    logic              in_range;
    logic [BANK_W-1:0] ib;
    logic              inj_fire;
    act_e              act;
    logic [DATA_W-1:0] st_new;
    logic              sel_gctl, sel_gst, sel_bank;
    logic [BANK_W-1:0] widx;
    logic [1:0]        wfld;
    logic              en_cfg;

    assign cnt       = q.cap[7:0];
    assign in_range  = (inj_bank < cnt) && (inj_bank < NB8);
    assign ib        = inj_bank[BANK_W-1:0];
    assign inj_ready = !reg_wr_en;
    assign inj_fire  = inj_valid && inj_ready;
    assign mce_req   = q.mce;
    assign rst_req   = q.rst;

    mcb_decide u_decide (
        .in_range    (in_range),
        .new_st      (inj_status),
        .old_st      (q.bank[ib][F_STAT]),
        .ctl_present (q.cap[CTLP_BIT]),
        .gctl_ones   (&q.gctl),
        .bctl_ones   (&q.bank[ib][F_CTL]),
        .in_progress (q.gst[MCIP_BIT]),
        .cr_en       (cr_mc_enable),
        .act         (act),
        .st_out      (st_new)
    );

    mcb_regmap #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_regmap (
        .addr     (reg_addr),
        .cnt      (cnt),
        .cap      (q.cap),
        .gctl     (q.gctl),
        .gst      (q.gst),
        .bank     (q.bank),
        .rdata    (reg_rdata),
        .sel_gctl (sel_gctl),
        .sel_gst  (sel_gst),
        .sel_bank (sel_bank),
        .bidx     (widx),
        .fld      (wfld)
    );

    // Reset image, chosen from the configuration pins
    always_comb begin
        en_cfg = (cfg_family >= 4'd6) && cfg_feat_chk && cfg_feat_arch;
        rv     = '0;
        if (en_cfg) begin
            rv.cap            = '0;
            rv.cap[7:0]       = (CB8 < NB8) ? CB8 : NB8;
            rv.cap[CTLP_BIT]  = 1'b1;
            rv.gctl           = '1;
            for (int b = 0; b < NUM_BANKS; b++) begin
                rv.bank[b][F_CTL] = '1;
            end
        end
    end

    always_comb begin
        d     = q;
        d.mce = 1'b0;
        if (rst_ack) d.rst = 1'b0;
        if (inj_fire) begin
            unique case (act)
                ACT_RESET: d.rst = 1'b1;
                ACT_UC_REC: begin
                    d.bank[ib][F_ADDR] = inj_addr;
                    d.bank[ib][F_MISC] = inj_misc;
                    d.bank[ib][F_STAT] = st_new;
                    d.gst              = inj_gstatus;
                    d.mce              = 1'b1;
                end
                ACT_CE_REC: begin
                    d.bank[ib][F_ADDR] = inj_addr;
                    d.bank[ib][F_MISC] = inj_misc;
                    d.bank[ib][F_STAT] = st_new;
                end
                ACT_OVER_ONLY: d.bank[ib][F_STAT] = st_new;
                default: ;
            endcase
        end else if (reg_wr_en) begin
            if (sel_gctl) d.gctl = reg_wdata;
            if (sel_gst)  d.gst  = reg_wdata;
            if (sel_bank) d.bank[widx][wfld] = reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= rv;
        else        q <= d;
    end

    // R5
    rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !rst_ack) |=> rst_req);

    // R5
    rst_norec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> ($stable(q.bank) && $stable(q.gst) && !mce_req));

    // R6
    mce_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mce_req |-> $past(inj_valid && inj_ready && inj_status[UC_BIT] && inj_status[VAL_BIT]));

    // R6
    mce_gst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mce_req |-> (q.gst == $past(inj_gstatus)));

    // R2
    noval_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid && inj_ready && !inj_status[VAL_BIT]) |=> ($stable(q.bank) && !mce_req));

    // R10
    wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> !inj_ready);
endmodule

// File: tb/mcb_recorder_tb.sv
module mcb_recorder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 4;
    localparam int CAPB = 3;
    localparam logic [63:0] VAL  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] OVER = 64'h4000_0000_0000_0000;
    localparam logic [63:0] UC   = 64'h2000_0000_0000_0000;

    logic clk = 0, rst_n = 0;
    logic [3:0] cfg_family = 4'd6;
    logic cfg_feat_chk = 1, cfg_feat_arch = 1, cr_mc_enable = 1;
    logic inj_valid = 0, inj_ready;
    logic [7:0] inj_bank = 0;
    logic [63:0] inj_status = 0, inj_gstatus = 0, inj_addr = 0, inj_misc = 0;
    logic [7:0] reg_addr = 0;
    logic reg_wr_en = 0;
    logic [63:0] reg_wdata = 0, reg_rdata;
    logic mce_req, rst_req, rst_ack = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcb_recorder #(.NUM_BANKS(NB), .CAP_BANKS(CAPB)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_family(cfg_family), .cfg_feat_chk(cfg_feat_chk),
        .cfg_feat_arch(cfg_feat_arch), .cr_mc_enable(cr_mc_enable), .inj_valid(inj_valid),
        .inj_ready(inj_ready), .inj_bank(inj_bank), .inj_status(inj_status),
        .inj_gstatus(inj_gstatus), .inj_addr(inj_addr), .inj_misc(inj_misc),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mce_req(mce_req), .rst_req(rst_req), .rst_ack(rst_ack)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0, chk_on = 0;
    logic exp_mce = 0, exp_rst = 0;

    // reference model state
    bit          m_en;
    logic [63:0] m_gctl, m_gst;
    logic [63:0] m_ctl[NB], m_st[NB], m_ad[NB], m_mi[NB];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int mcount();
        return m_en ? CAPB : 0;
    endfunction

    function automatic logic [63:0] mread(input logic [7:0] a);
        int b;
        if (a == 8'h00) return m_en ? 64'h103 : 64'h0;
        if (a == 8'h01) return m_gctl;
        if (a == 8'h02) return m_gst;
        if (a >= 8'h40 && a < 8'h80) begin
            b = int'(a[5:2]);
            if (b >= mcount()) return 64'h0;
            case (a[1:0])
                2'd0: return m_ctl[b];
                2'd1: return m_st[b];
                2'd2: return m_ad[b];
                default: return m_mi[b];
            endcase
        end
        return 64'h0;
    endfunction

    // R5 R6: requests compared every cycle against the model
    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk(mce_req === exp_mce, "R6 mce_req", 64'(mce_req), 64'(exp_mce));
            chk(rst_req === exp_rst, "R5 rst_req", 64'(rst_req), 64'(exp_rst));
        end
    end

    task automatic do_reset(input logic [3:0] fam, input logic f1, input logic f2);
        chk_on = 0;
        @(negedge clk);
        rst_n = 0; cfg_family = fam; cfg_feat_chk = f1; cfg_feat_arch = f2;
        inj_valid = 0; reg_wr_en = 0; rst_ack = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_en = (fam >= 4'd6) && f1 && f2;
        m_gctl = m_en ? '1 : '0;
        m_gst = 0;
        for (int b = 0; b < NB; b++) begin
            m_ctl[b] = m_en ? '1 : '0;
            m_st[b] = 0; m_ad[b] = 0; m_mi[b] = 0;
        end
        exp_mce = 0; exp_rst = 0;
        chk_on = 1;
    endtask

    // one clock of stimulus; model advanced in step
    task automatic cyc(input logic iv, input logic [7:0] bk, input logic [63:0] st,
                       input logic [63:0] gs, input logic [63:0] ad, input logic [63:0] mi,
                       input logic we, input logic [7:0] wa, input logic [63:0] wd, input logic ack);
        logic nm, nr;
        int b;
        @(negedge clk);
        inj_valid = iv; inj_bank = bk; inj_status = st; inj_gstatus = gs;
        inj_addr = ad; inj_misc = mi; reg_wr_en = we; reg_addr = wa; reg_wdata = wd; rst_ack = ack;
        #1;
        chk(inj_ready === !we, "R10 inj_ready", 64'(inj_ready), 64'(!we));
        nm = 0; nr = exp_rst;
        if (ack) nr = 0;
        b = int'(bk);
        if (we) begin
            if (wa == 8'h01) m_gctl = wd;
            else if (wa == 8'h02) m_gst = wd;
            else if (wa >= 8'h40 && wa < 8'h80 && int'(wa[5:2]) < mcount()) begin
                case (wa[1:0])
                    2'd0: m_ctl[wa[5:2]] = wd;
                    2'd1: m_st[wa[5:2]] = wd;
                    2'd2: m_ad[wa[5:2]] = wd;
                    default: m_mi[wa[5:2]] = wd;
                endcase
            end
        end else if (iv && b < mcount() && st[63]) begin
            if (st[61]) begin
                if (m_gctl == '1 && m_ctl[b] == '1) begin
                    if (m_gst[2] || !cr_mc_enable) nr = 1;
                    else begin
                        m_st[b] = m_st[b][63] ? (st | OVER) : st;
                        m_ad[b] = ad; m_mi[b] = mi; m_gst = gs; nm = 1;
                    end
                end
            end else if (m_st[b][63] && m_st[b][61]) begin
                m_st[b] = m_st[b] | OVER;
            end else begin
                m_st[b] = m_st[b][63] ? (st | OVER) : st;
                m_ad[b] = ad; m_mi[b] = mi;
            end
        end
        @(posedge clk); #1;
        exp_mce = nm; exp_rst = nr;
    endtask

    task automatic inj(input logic [7:0] bk, input logic [63:0] st, input logic [63:0] gs,
                       input logic [63:0] ad, input logic [63:0] mi);
        cyc(1, bk, st, gs, ad, mi, 0, 8'h00, 0, 0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] v);
        cyc(0, 0, 0, 0, 0, 0, 1, a, v, 0);
    endtask

    task automatic idle(input logic ack);
        cyc(0, 0, 0, 0, 0, 0, 0, 8'h00, 0, ack);
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        @(negedge clk);
        inj_valid = 0; reg_wr_en = 0; rst_ack = 0; reg_addr = a;
        #1;
        chk(reg_rdata === mread(a), req, reg_rdata, mread(a));
        @(posedge clk); #1;
        exp_mce = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset(4'd6, 1, 1);
        // R1 reset state
        rd(8'h00, "R1 cap");
        rd(8'h01, "R1 gctl");
        rd(8'h40, "R1 bank0 ctl");
        rd(8'h48, "R1 bank2 ctl");
        rd(8'h02, "R1 gstatus");
        rd(8'h4C, "R9 bank3 ctl reads zero");
        // R7 corrected error into empty bank, then onto corrected entry
        inj(0, VAL | 64'h11, 0, 64'hA0, 64'hB0);
        rd(8'h41, "R7 st0 first");
        rd(8'h42, "R7 addr0 first");
        inj(0, VAL | 64'h22, 0, 64'hA1, 64'hB1);
        rd(8'h41, "R7 st0 overflow");
        rd(8'h43, "R7 misc0 second");
        // R6 uncorrected accepted
        inj(1, VAL | UC | 64'h33, 64'h5, 64'hC0, 64'hD0);
        idle(0);
        rd(8'h45, "R6 st1");
        rd(8'h02, "R6 gstatus");
        rd(8'h46, "R6 addr1");
        // R8 corrected onto valid uncorrected
        inj(1, VAL | 64'h44, 0, 64'hEE, 64'hFF);
        rd(8'h45, "R8 st1 over only");
        rd(8'h46, "R8 addr1 kept");
        rd(8'h47, "R8 misc1 kept");
        // R5 in progress -> reset request, held until ack
        inj(0, VAL | UC | 64'h55, 0, 64'h1, 64'h2);
        idle(0); idle(0);
        rd(8'h41, "R5 st0 untouched");
        rd(8'h02, "R5 gstatus untouched");
        idle(1); idle(0);
        // R5 cr disabled
        wr(8'h02, 0);
        cr_mc_enable = 0;
        inj(2, VAL | UC | 64'h66, 64'h4, 64'h3, 64'h4);
        rd(8'h49, "R5 st2 untouched");
        cyc(0, 0, 0, 0, 0, 0, 0, 8'h00, 0, 1);
        cr_mc_enable = 1;
        // R6 uncorrected onto valid corrected entry
        inj(0, VAL | UC | 64'h77, 64'h4, 64'h5, 64'h6);
        rd(8'h41, "R6 st0 overflow");
        wr(8'h02, 0);
        // R2 ignored injections
        inj(3, VAL | 64'h88, 0, 64'h7, 64'h8);
        rd(8'h4D, "R2 bank3 reads zero");
        inj(2, 64'h99, 0, 64'h7, 64'h8);
        rd(8'h49, "R2 st2 no valid");
        rd(8'h4A, "R2 addr2 no valid");
        // R4 bank control not all ones
        wr(8'h48, 64'hFFFF_FFFF_FFFF_FFF0);
        inj(2, VAL | UC, 64'h4, 64'h9, 64'h9);
        rd(8'h49, "R4 st2 dropped");
        wr(8'h48, '1);
        // R3 global control not all ones
        wr(8'h01, 64'hFFFF_FFFF_FFFF_FFFE);
        inj(2, VAL | UC, 64'h4, 64'h9, 64'h9);
        rd(8'h49, "R3 st2 dropped");
        rd(8'h02, "R3 gstatus kept");
        wr(8'h01, '1);
        // R10 collision: write and injection in same cycle
        cyc(1, 2, VAL | 64'hAB, 0, 64'h70, 64'h71, 1, 8'h4A, 64'h55, 0);
        rd(8'h4A, "R10 write applied");
        rd(8'h49, "R10 injection not taken");
        // R9 read-only cap, out-of-range write
        wr(8'h00, 0);
        rd(8'h00, "R9 cap read-only");
        wr(8'h4E, 64'h1234);
        rd(8'h4E, "R9 bank3 write ignored");
        rd(8'h90, "R9 unmapped reads zero");
        // R1 disabled configurations
        do_reset(4'd5, 1, 1);
        rd(8'h00, "R1 cap off family");
        rd(8'h01, "R1 gctl off family");
        cr_mc_enable = 0;
        inj(0, VAL | UC, 64'h4, 64'h1, 64'h1);
        rd(8'h41, "R1 disabled ignores");
        cr_mc_enable = 1;
        do_reset(4'd6, 1, 0);
        rd(8'h00, "R1 cap missing flag");
        rd(8'h40, "R1 bank ctl missing flag");
        do_reset(4'd7, 1, 1);
        rd(8'h00, "R1 cap family 7");
        idle(0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule